// File: doc/BRIEF.md
# Least-Recently-Issued Thread Picker

This block chooses, every cycle, which of several hardware threads (four by default) may place an instruction into a single-issue, in-order pipeline. Each thread carries a ready flag. Among the threads that are ready, the pick goes to the one that issued longest ago. The answer comes out as a one-hot select vector plus a valid bit.

The pipeline reports the type of the instruction that is issuing in the current cycle. A branch, multiply or divide parks its thread until a completion event wakes it. A load parks its thread only for a short, fixed gap and then re-admits it on the guess that the load hits, so a dependent instruction can catch bypassed data. A miss report cancels that guess and holds the thread until the line fill returns. Traps and resource conflicts park a thread through a per-thread stall input. When a multiply or divide finds the shared unit held by another thread, the instruction is rolled back: its thread is parked and does not count as having issued.

Top module: `mt_thread_picker`

## Requirements
- R1: After reset no thread is ready, `valid_o` is 0, `sel_o` is 0, and the age order from oldest to youngest is thread 0, 1, 2, 3.
- R2: `valid_o` is 1 exactly when at least one thread is ready; `sel_o` then has a single bit set at the index of the oldest ready thread, and is all zero otherwise.
- R3: A thread that issues (selected, valid, not rolled back) moves to the youngest position of the age order on the next cycle; the relative order of the other threads is kept.
- R4: In a cycle with `valid_o` at 0, the age order does not change.
- R5: A thread that issues with `iss_long_i` or `iss_muldiv_i` set is not ready from the next cycle until its `wake_i` bit is seen.
- R6: A thread that issues with `iss_load_i` set (and no long flag) is not ready for `LD_GAP` cycles and is then ready again without any wake.
- R7: A `miss_i` bit makes its thread not ready from the next cycle and marks a miss as pending; while pending, `wake_i` for that thread is ignored and only `fill_i` makes it ready again. `fill_i` is ignored for a thread with no pending miss.
- R8: A `stall_i` bit (trap or resource conflict) makes its thread not ready from the next cycle until woken, and cancels any running load re-admission gap.
- R9: When the issuing instruction has `iss_muldiv_i` and `unit_busy_i` both set, the selected thread is parked as in R5 but the age order is left unchanged.
- R10: Per thread, same-cycle events take effect in this order of precedence: miss, stall, issue effects (park, then load gap), fill, wake, gap count-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_load_i | input | 1 | Issuing instruction is a load |
| iss_long_i | input | 1 | Issuing instruction is a branch or other long-latency operation |
| iss_muldiv_i | input | 1 | Issuing instruction is a multiply or divide |
| unit_busy_i | input | 1 | Multiply/divide unit is held by another thread |
| miss_i | input | NT | Per-thread cache miss report |
| stall_i | input | NT | Per-thread trap or resource conflict |
| fill_i | input | NT | Per-thread miss fill complete |
| wake_i | input | NT | Per-thread long-latency completion |
| sel_o | output | NT | One-hot thread selected this cycle |
| valid_o | output | 1 | A thread is selected this cycle |

## Verification
The interesting collision is a thread's own issue meeting an asynchronous event in the same cycle: a miss report arriving while that thread issues, a wake landing on a thread that is being stalled, or a rollback coinciding with wakes of other threads. Directed steps set these up so that the thread whose state is in question would be the oldest ready thread afterwards, so a wrong precedence changes `sel_o` in the following cycle. A long randomized sweep then throws all events at all threads with overlapping probabilities and compares every cycle's select and valid against a bench model built from the precedence list.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    // Resolved per-thread event, one per cycle, after precedence.
    typedef enum logic [2:0] {
        EV_NONE,
        EV_MISS,
        EV_STALL,
        EV_PARK,
        EV_SPEC,
        EV_FILL,
        EV_WAKE
    } thr_ev_e;

endpackage

// File: rtl/mtp_thread_state.sv
module mtp_thread_state
    import mtp_pkg::*;
#(
    parameter int LD_GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic miss_i,
    input  logic stall_i,
    input  logic issued_i,
    input  logic park_i,
    input  logic spec_i,
    input  logic fill_i,
    input  logic wake_i,
    output logic rdy_o
);

    localparam int CW = (LD_GAP > 1) ? $clog2(LD_GAP + 1) : 1;

    typedef struct packed {
        logic          rdy;
        logic          miss_pend;
        logic [CW-1:0] gap;
    } thr_st_t;

    thr_st_t st_d, st_q;
    thr_ev_e ev;

    always_comb begin
        // precedence of same-cycle events
        if (miss_i)                         ev = EV_MISS;
        else if (stall_i)                   ev = EV_STALL;
        else if (issued_i && park_i)        ev = EV_PARK;
        else if (issued_i && spec_i)        ev = EV_SPEC;
        else if (fill_i && st_q.miss_pend)  ev = EV_FILL;
        else if (wake_i && !st_q.miss_pend) ev = EV_WAKE;
        else                                ev = EV_NONE;

        st_d = st_q;
        unique case (ev)
            EV_MISS: begin
                st_d.rdy       = 1'b0;
                st_d.miss_pend = 1'b1;
                st_d.gap       = '0;
            end
            EV_STALL, EV_PARK: begin
                st_d.rdy = 1'b0;
                st_d.gap = '0;
            end
            EV_SPEC: begin
                st_d.rdy = 1'b0;
                st_d.gap = CW'(LD_GAP);
            end
            EV_FILL: begin
                st_d.rdy       = 1'b1;
                st_d.miss_pend = 1'b0;
                st_d.gap       = '0;
            end
            EV_WAKE: begin
                st_d.rdy = 1'b1;
                st_d.gap = '0;
            end
            default: begin
                if (st_q.gap != '0) begin
                    st_d.gap = st_q.gap - CW'(1);
                    if (st_q.gap == CW'(1)) st_d.rdy = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy_o = st_q.rdy;

endmodule

// File: rtl/mtp_lru_order.sv
module mtp_lru_order #(
    parameter int NT = 4,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    rdy_i,
    input  logic             commit_i,
    output logic [NT-1:0]    sel_o,
    output logic             valid_o,
    output logic [NT*TW-1:0] ord_o
);

    // ent[0] is the oldest thread, ent[NT-1] the youngest
    typedef struct packed {
        logic [NT-1:0][TW-1:0] ent;
    } ord_t;

    ord_t          st_d, st_q;
    logic          found;
    logic [TW-1:0] win_pos;
    logic [TW-1:0] win_id;

    always_comb begin
        found   = 1'b0;
        win_pos = '0;
        win_id  = '0;
        for (int p = 0; p < NT; p++) begin
            if (!found && rdy_i[st_q.ent[p]]) begin
                found   = 1'b1;
                win_pos = TW'(p);
                win_id  = st_q.ent[p];
            end
        end

        st_d = st_q;
        if (found && commit_i) begin
            for (int p = 0; p < NT - 1; p++) begin
                if (p >= int'(win_pos)) st_d.ent[p] = st_q.ent[p+1];
            end
            st_d.ent[NT-1] = win_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NT; p++) st_q.ent[p] <= TW'(p);
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = found;
    assign sel_o   = found ? (NT'(1) << win_id) : '0;
    assign ord_o   = st_q.ent;

endmodule

// File: rtl/mt_thread_picker.sv
module mt_thread_picker #(
    parameter int NT     = 4,
    parameter int LD_GAP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_load_i,
    input  logic          iss_long_i,
    input  logic          iss_muldiv_i,
    input  logic          unit_busy_i,
    input  logic [NT-1:0] miss_i,
    input  logic [NT-1:0] stall_i,
    input  logic [NT-1:0] fill_i,
    input  logic [NT-1:0] wake_i,
    output logic [NT-1:0] sel_o,
    output logic          valid_o
);

    localparam int TW = (NT > 1) ? $clog2(NT) : 1;

    logic [NT-1:0]    rdy;
    logic [NT-1:0]    issued;
    logic             park;
    logic             rollback;
    logic             commit;
    logic [NT*TW-1:0] ord_flat;

    assign park     = iss_long_i | iss_muldiv_i;
    assign rollback = iss_muldiv_i & unit_busy_i;
    assign commit   = ~rollback;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign issued[t] = valid_o & sel_o[t];

        mtp_thread_state #(
            .LD_GAP(LD_GAP)
        ) i_state (
            .clk     (clk),
            .rst_n   (rst_n),
            .miss_i  (miss_i[t]),
            .stall_i (stall_i[t]),
            .issued_i(issued[t]),
            .park_i  (park),
            .spec_i  (iss_load_i),
            .fill_i  (fill_i[t]),
            .wake_i  (wake_i[t]),
            .rdy_o   (rdy[t])
        );
    end

    mtp_lru_order #(
        .NT(NT)
    ) i_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_i   (rdy),
        .commit_i(commit),
        .sel_o   (sel_o),
        .valid_o (valid_o),
        .ord_o   (ord_flat)
    );

endmodule

// File: rtl/mtp_checker.sv
module mtp_checker #(
    parameter int NT = 4,
    parameter int TW = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_long_i,
    input logic             iss_muldiv_i,
    input logic             unit_busy_i,
    input logic [NT-1:0]    miss_i,
    input logic [NT-1:0]    stall_i,
    input logic [NT-1:0]    sel_o,
    input logic             valid_o,
    input logic [NT*TW-1:0] ord_flat
);

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $countones(sel_o) == 1);

    p_idle_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> sel_o == '0);

    p_idle_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> $stable(ord_flat));

    p_rollback_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && iss_muldiv_i && unit_busy_i) |=> $stable(ord_flat));

    p_issue_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !(iss_muldiv_i && unit_busy_i)) |=> !$stable(ord_flat) || $past(sel_o) == (NT'(1) << ord_flat[NT*TW-1 -: TW]));

    for (genvar t = 0; t < NT; t++) begin : g_thr
        p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
            miss_i[t] |=> !sel_o[t]);

        p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            stall_i[t] |=> !sel_o[t]);

        p_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_o && sel_o[t] && (iss_long_i || iss_muldiv_i)) |=> !sel_o[t]);
    end

endmodule

bind mt_thread_picker mtp_checker #(
    .NT(NT),
    .TW(TW)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_long_i  (iss_long_i),
    .iss_muldiv_i(iss_muldiv_i),
    .unit_busy_i (unit_busy_i),
    .miss_i      (miss_i),
    .stall_i     (stall_i),
    .sel_o       (sel_o),
    .valid_o     (valid_o),
    .ord_flat    (ord_flat)
);

// File: tb/test_mt_thread_picker.sv
module test_mt_thread_picker;

    localparam int NT     = 4;
    localparam int LD_GAP = 1;
    localparam int PERIOD = 10;
    localparam int SWEEP  = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_load, iss_long, iss_muldiv, unit_busy;
    logic [NT-1:0] miss, stall, fill, wake;
    logic [NT-1:0] sel;
    logic          valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    bit m_rdy [NT];
    bit m_mp  [NT];
    int m_gap [NT];
    int m_ord [NT];

    always #(PERIOD/2) clk = ~clk;

    mt_thread_picker #(.NT(NT), .LD_GAP(LD_GAP)) i_mt_thread_picker (
        .clk(clk), .rst_n(rst_n),
        .iss_load_i(iss_load), .iss_long_i(iss_long),
        .iss_muldiv_i(iss_muldiv), .unit_busy_i(unit_busy),
        .miss_i(miss), .stall_i(stall), .fill_i(fill), .wake_i(wake),
        .sel_o(sel), .valid_o(valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        iss_load = 0; iss_long = 0; iss_muldiv = 0; unit_busy = 0;
        miss = '0; stall = '0; fill = '0; wake = '0;
    endtask

    function automatic int m_pick();
        for (int p = 0; p < NT; p++) if (m_rdy[m_ord[p]]) return m_ord[p];
        return -1;
    endfunction

    // compare outputs with the model, advance one clock, advance the model
    task automatic cyc();
        int w;
        bit n_rdy [NT];
        bit n_mp  [NT];
        int n_gap [NT];
        w = m_pick();
        chk("R2 R10 model valid", 32'(valid), 32'(w >= 0));
        chk("R2 R10 model select", 32'(sel), (w >= 0) ? (32'd1 << w) : 32'd0);
        for (int t = 0; t < NT; t++) begin
            bit iss;
            iss = (w == t);
            n_rdy[t] = m_rdy[t]; n_mp[t] = m_mp[t]; n_gap[t] = m_gap[t];
            if (miss[t]) begin n_rdy[t] = 0; n_mp[t] = 1; n_gap[t] = 0; end
            else if (stall[t]) begin n_rdy[t] = 0; n_gap[t] = 0; end
            else if (iss && (iss_long || iss_muldiv)) begin n_rdy[t] = 0; n_gap[t] = 0; end
            else if (iss && iss_load) begin n_rdy[t] = 0; n_gap[t] = LD_GAP; end
            else if (fill[t] && m_mp[t]) begin n_rdy[t] = 1; n_mp[t] = 0; n_gap[t] = 0; end
            else if (wake[t] && !m_mp[t]) begin n_rdy[t] = 1; n_gap[t] = 0; end
            else if (m_gap[t] > 0) begin
                n_gap[t] = m_gap[t] - 1;
                if (m_gap[t] == 1) n_rdy[t] = 1;
            end
        end
        @(posedge clk);
        if (w >= 0 && !(iss_muldiv && unit_busy)) begin
            int k;
            k = 0;
            for (int p = 0; p < NT; p++) if (m_ord[p] != w) begin m_ord[k] = m_ord[p]; k++; end
            m_ord[NT-1] = w;
        end
        for (int t = 0; t < NT; t++) begin
            m_rdy[t] = n_rdy[t]; m_mp[t] = n_mp[t]; m_gap[t] = n_gap[t];
        end
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_in();
        for (int t = 0; t < NT; t++) begin
            m_rdy[t] = 0; m_mp[t] = 0; m_gap[t] = 0; m_ord[t] = t;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 valid after reset", 32'(valid), 0);
        chk("R1 select after reset", 32'(sel), 0);
        wake = 4'b1111; cyc();
        chk("R1 thread 0 oldest", 32'(sel), 32'b0001);
        cyc();                                  // t0 issues plain
        chk("R3 issuer becomes youngest", 32'(sel), 32'b0010);
        iss_long = 1; cyc();                    // t1 parks
        chk("R5 long op parks thread", 32'(sel), 32'b0100);
        iss_load = 1; cyc();                    // t2 load gap
        chk("R6 load gap hides thread", 32'(sel), 32'b1000);
        cyc();                                  // t3 issues, t2 re-admitted
        chk("R6 order after wrap", 32'(sel), 32'b0001);
        cyc();                                  // t0 issues
        chk("R6 speculative re-admission", 32'(sel), 32'b0100);
        miss = 4'b0100; cyc();                  // miss on issuing t2
        chk("R7 miss withdraws thread", 32'(sel), 32'b1000);
        wake = 4'b0100; stall = 4'b1001; cyc(); // t3 issues, t0/t3 stalled
        chk("R7 R8 wake ignored, stalls park", 32'(valid), 0);
        fill = 4'b0100; cyc();                  // idle cycle, fill returns
        chk("R7 fill restores thread", 32'(sel), 32'b0100);
        chk("R4 order kept while idle", 32'(valid), 1);
        iss_muldiv = 1; unit_busy = 1; wake = 4'b1001; cyc();
        chk("R9 rollback parks thread", 32'(sel), 32'b0001);
        wake = 4'b0100; cyc();                  // t0 issues plain
        chk("R9 rollback left order", 32'(sel), 32'b0100);
        stall = 4'b0010; wake = 4'b0010; cyc(); // t2 issues, t1 stall+wake
        chk("R10 stall beats wake", 32'(sel), 32'b1000);
        fill = 4'b1111; cyc();                  // no miss pending anywhere
        chk("R7 fill without miss ignored", 32'(sel), 32'b0001);

        // randomized sweep against the model
        for (int i = 0; i < SWEEP; i++) begin
            iss_load   = ($urandom_range(0, 3) == 0);
            iss_long   = ($urandom_range(0, 4) == 0);
            iss_muldiv = ($urandom_range(0, 5) == 0);
            unit_busy  = ($urandom_range(0, 1) == 0);
            for (int t = 0; t < NT; t++) begin
                miss[t]  = ($urandom_range(0, 15) == 0);
                stall[t] = ($urandom_range(0, 11) == 0);
                fill[t]  = ($urandom_range(0, 3) == 0);
                wake[t]  = ($urandom_range(0, 4) == 0);
            end
            cyc();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule